// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Cache Lookup

This block is the read lookup path of a first-level cache. The set index is taken from address bits that lie inside the page offset, so they are the same before and after translation. In the cycle a request arrives, the block reads the indexed set of its tag and data arrays and, at the same time, sends the virtual page number to an external TLB. When the physical page number comes back, the block compares it with every stored tag of that set in parallel. The stored tags are physical. Two virtual pages that map to one physical page therefore find the same line.

The outcome is registered and appears in the cycle after the request. There are three outcomes. A hit returns the line. A miss reports the physical line address so that a refill can be fetched. A translation failure reports a fault. A refill line is written through the fill port into the set named by its physical line address. The way it replaces comes from a round-robin pointer kept for each set. A parameter set whose index and line-offset fields do not fit inside the page offset is rejected when the design is elaborated.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_fault` are low, and every line is invalid. A first lookup to any address therefore misses.
- R2: In the cycle of a request, `tlb_req` equals `req_valid` and `tlb_vpn` equals `req_vaddr[VA_W-1:PAGE_BITS]`.
- R3: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. Back-to-back requests give back-to-back responses.
- R4: A request whose translated tag matches a valid way of the set at index `req_vaddr[OFF_BITS+SET_BITS-1:OFF_BITS]` gives `rsp_hit` and returns that way's line on `rsp_data`.
- R5: The tag comparison uses the physical address. Two virtual pages that translate to the same physical page hit the same line. A different physical page at the same index misses.
- R6: When `tlb_hit` is low or `tlb_fault` is high, the response has `rsp_fault` high and `rsp_hit` and `rsp_miss` low. This holds even when a stored tag matches.
- R7: A translated request that matches no way gives `rsp_miss`. `miss_line_addr` then equals `{tlb_ppn, req_vaddr[PAGE_BITS-1:OFF_BITS]}`.
- R8: A fill writes its line into the set named by `fill_line_addr[SET_BITS-1:0]`. It uses the way given by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one per fill, wrapping after the last way. With two ways, the third fill to a set evicts the first.
- R9: When a fill and a lookup of the same line fall in the same cycle, the lookup sees the set's contents from before the fill. The next lookup sees the new line.
- R10: While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. While it is low, none of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VA_W | Virtual byte address |
| tlb_req | output | 1 | Translation request, same cycle as `req_valid` |
| tlb_vpn | output | VA_W-PAGE_BITS | Virtual page number to translate |
| tlb_ppn | input | PA_W-PAGE_BITS | Translated physical page number |
| tlb_hit | input | 1 | Translation found |
| tlb_fault | input | 1 | Access not permitted |
| fill_valid | input | 1 | Refill line write |
| fill_line_addr | input | PA_W-OFF_BITS | Physical line address of the refill |
| fill_data | input | LINE_W | Refill line |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line found |
| rsp_miss | output | 1 | Line absent, refill needed |
| rsp_fault | output | 1 | Translation failed |
| rsp_data | output | LINE_W | Line on hit, zero otherwise |
| miss_line_addr | output | PA_W-OFF_BITS | Physical line address on miss |

## Verification
A refill write and a lookup can land on the same set in the same clock cycle. In that cycle the array is written at the edge while the lookup compares against what it read before the edge. The bench drives a fill of a line together with a lookup of that same line in one cycle. It expects a miss for that lookup and a hit with the new data on the next lookup. A second overlap also gets attention: a translation fault on a set whose stored tag matches. There the fault must win over the match.

// File: rtl/vipt_pkg.sv
// Shared definitions for the cache lookup path.
// Assumes nothing beyond elaboration-time integer parameters.
package vipt_pkg;

    // Width of an index selecting one of n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Outcome of one lookup, decided in the request cycle.
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_MISS  = 2'd2,
        OUT_FAULT = 2'd3
    } outcome_t;

endpackage

// File: rtl/vipt_tag_store.sv
// Tag, valid and line storage, one bank per way.
// Reads are combinational on rd_set. A write lands at the clock edge, so a
// read in the same cycle returns the old contents. Only valid bits are reset.
module vipt_tag_store
    import vipt_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 128,
    localparam int SET_W = idx_width(SETS),
    localparam int WAY_W = idx_width(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [LINE_W-1:0]            wr_data,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][LINE_W-1:0]  rd_data
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]  tag_mem [SETS];
        logic [LINE_W-1:0] dat_mem [SETS];
        logic [SETS-1:0]   vld;
        logic              sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        // Valid bits: cleared by reset, set when this way is filled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= '0;
            end else if (sel) begin
                vld[wr_set] <= 1'b1;
            end
        end

        // Tag and line contents: written on fill, no reset needed.
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_mem[wr_set] <= wr_tag;
                dat_mem[wr_set] <= wr_data;
            end
        end

        assign rd_valid[w] = vld[rd_set];
        assign rd_tag[w]   = tag_mem[rd_set];
        assign rd_data[w]  = dat_mem[rd_set];
    end

endmodule

// File: rtl/vipt_way_match.sv
// Parallel physical-tag comparison across all ways of one set.
// Assumes at most one valid way holds a given tag, so the selected line is
// the OR of the matching ways' lines.
module vipt_way_match #(
    parameter int WAYS   = 2,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 128
) (
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    input  logic [WAYS-1:0][LINE_W-1:0]  way_data,
    input  logic [TAG_W-1:0]             phys_tag,
    output logic                         any_match,
    output logic [LINE_W-1:0]            match_data
);

    // Compare every way at once and merge the matching line.
    always_comb begin
        any_match  = 1'b0;
        match_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_valid[w] && (way_tag[w] == phys_tag)) begin
                any_match  = 1'b1;
                match_data = match_data | way_data[w];
            end
        end
    end

endmodule

// File: rtl/vipt_rr_victim.sv
// Round-robin victim pointer, one per set.
// The pointer of the addressed set advances by one on each fill and wraps
// after the last way. All pointers start at way 0.
module vipt_rr_victim
    import vipt_pkg::*;
#(
    parameter int SETS = 16,
    parameter int WAYS = 2,
    localparam int SET_W = idx_width(SETS),
    localparam int WAY_W = idx_width(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [SET_W-1:0] set,
    output logic [WAY_W-1:0] victim
);

    logic [WAY_W-1:0] ptr [SETS];

    // Pointer update: reset all, step the addressed set on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr[s] <= '0;
        end else if (advance) begin
            ptr[set] <= (ptr[set] == WAY_W'(WAYS - 1)) ? '0 : ptr[set] + 1'b1;
        end
    end

    assign victim = ptr[set];

endmodule

// File: rtl/vipt_lookup.sv
// Top of the virtually-indexed, physically-tagged lookup path.
// In the request cycle the set is read using untranslated page-offset bits
// while the page number goes to the TLB. The TLB answers combinationally in
// the same cycle. The compare result is registered, so the response follows
// one cycle later. Assumes SET_BITS + OFF_BITS <= PAGE_BITS.
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 28,
    parameter int PAGE_BITS = 12,
    parameter int OFF_BITS  = 4,
    parameter int SET_BITS  = 4,
    parameter int WAYS      = 2,
    parameter int LINE_W    = 128,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS,
    localparam int LINE_A_W = PA_W - OFF_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_vaddr,
    output logic                tlb_req,
    output logic [VPN_W-1:0]    tlb_vpn,
    input  logic [PPN_W-1:0]    tlb_ppn,
    input  logic                tlb_hit,
    input  logic                tlb_fault,
    input  logic                fill_valid,
    input  logic [LINE_A_W-1:0] fill_line_addr,
    input  logic [LINE_W-1:0]   fill_data,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic                rsp_fault,
    output logic [LINE_W-1:0]   rsp_data,
    output logic [LINE_A_W-1:0] miss_line_addr
);

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = LINE_A_W - SET_BITS;
    localparam int WAY_W = idx_width(WAYS);

    // Geometry guard: the index must not need translation.
    if (SET_BITS + OFF_BITS > PAGE_BITS) begin : g_bad_geometry
        $error("index and line offset exceed the page offset");
    end

    logic [SET_BITS-1:0]           look_set;
    logic [LINE_A_W-1:0]           look_line;
    logic [TAG_W-1:0]              look_tag;
    logic [WAYS-1:0]               rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]    rd_tag;
    logic [WAYS-1:0][LINE_W-1:0]   rd_data;
    logic                          any_match;
    logic [LINE_W-1:0]             match_data;
    logic [WAY_W-1:0]              victim;
    outcome_t                      outcome;
    logic                          unused_offset;

    assign unused_offset = ^req_vaddr[OFF_BITS-1:0];

    assign tlb_req   = req_valid;
    assign tlb_vpn   = req_vaddr[VA_W-1:PAGE_BITS];
    assign look_set  = req_vaddr[OFF_BITS +: SET_BITS];
    assign look_line = {tlb_ppn, req_vaddr[PAGE_BITS-1:OFF_BITS]};
    assign look_tag  = look_line[LINE_A_W-1:SET_BITS];

    vipt_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_set(look_set),
        .wr_en(fill_valid),
        .wr_set(fill_line_addr[SET_BITS-1:0]),
        .wr_way(victim),
        .wr_tag(fill_line_addr[LINE_A_W-1:SET_BITS]),
        .wr_data(fill_data),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data)
    );

    vipt_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_match (
        .way_valid(rd_valid), .way_tag(rd_tag), .way_data(rd_data),
        .phys_tag(look_tag),
        .any_match(any_match), .match_data(match_data)
    );

    vipt_rr_victim #(
        .SETS(SETS), .WAYS(WAYS)
    ) u_victim (
        .clk(clk), .rst_n(rst_n),
        .advance(fill_valid),
        .set(fill_line_addr[SET_BITS-1:0]),
        .victim(victim)
    );

    // Outcome decision: a failed translation overrides any tag match.
    always_comb begin
        if (!req_valid)                   outcome = OUT_NONE;
        else if (!tlb_hit || tlb_fault)   outcome = OUT_FAULT;
        else if (any_match)               outcome = OUT_HIT;
        else                              outcome = OUT_MISS;
    end

    // Response register: presents the outcome one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_miss       <= 1'b0;
            rsp_fault      <= 1'b0;
            rsp_data       <= '0;
            miss_line_addr <= '0;
        end else begin
            rsp_valid      <= (outcome != OUT_NONE);
            rsp_hit        <= (outcome == OUT_HIT);
            rsp_miss       <= (outcome == OUT_MISS);
            rsp_fault      <= (outcome == OUT_FAULT);
            rsp_data       <= (outcome == OUT_HIT) ? match_data : '0;
            miss_line_addr <= (outcome == OUT_MISS) ? look_line : '0;
        end
    end

endmodule

// File: rtl/vipt_lookup_chk.sv
// Checker for vipt_lookup, attached by bind. It observes ports only.
module vipt_lookup_chk #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 28,
    parameter int PAGE_BITS = 12,
    parameter int OFF_BITS  = 4,
    parameter int LINE_W    = 128
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [VA_W-1:0]             req_vaddr,
    input logic [PA_W-PAGE_BITS-1:0]   tlb_ppn,
    input logic                        tlb_hit,
    input logic                        tlb_fault,
    input logic                        rsp_valid,
    input logic                        rsp_hit,
    input logic                        rsp_miss,
    input logic                        rsp_fault,
    input logic [LINE_W-1:0]           rsp_data,
    input logic [PA_W-OFF_BITS-1:0]    miss_line_addr
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault);

    // R3
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R3
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    // R10
    idle_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_miss && !rsp_fault);

    // R6
    fault_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (!tlb_hit || tlb_fault) |=> rsp_fault && !rsp_hit);

    // R7
    miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && tlb_hit && !tlb_fault |=>
            (!rsp_miss || miss_line_addr ==
                {$past(tlb_ppn), $past(req_vaddr[PAGE_BITS-1:OFF_BITS])}));

    // R4
    data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_data == '0);

endmodule

bind vipt_lookup vipt_lookup_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
    .OFF_BITS(OFF_BITS), .LINE_W(LINE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tlb_ppn(tlb_ppn), .tlb_hit(tlb_hit), .tlb_fault(tlb_fault),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_data(rsp_data),
    .miss_line_addr(miss_line_addr)
);

// File: tb/sim_vipt_lookup.sv
// Scoreboard bench for vipt_lookup. A driver task queues the expected
// outcome of each lookup, and a monitor compares each response as it appears.
module sim_vipt_lookup;

    localparam int VA_W = 32, PA_W = 28, PAGE_BITS = 12, OFF_BITS = 4;
    localparam int LINE_W = 128;
    localparam int VPN_W = VA_W - PAGE_BITS, PPN_W = PA_W - PAGE_BITS;
    localparam int LA_W = PA_W - OFF_BITS;

    typedef struct {
        int              kind;   // 0 hit, 1 miss, 2 fault
        logic [LINE_W-1:0] data;
        logic [LA_W-1:0]   line;
        string             tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic tlb_req, tlb_hit, tlb_fault;
    logic [VPN_W-1:0] tlb_vpn;
    logic [PPN_W-1:0] tlb_ppn;
    logic fill_valid = 1'b0;
    logic [LA_W-1:0] fill_line_addr = '0;
    logic [LINE_W-1:0] fill_data = '0;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [LINE_W-1:0] rsp_data;
    logic [LA_W-1:0] miss_line_addr;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    vipt_lookup u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .tlb_req(tlb_req), .tlb_vpn(tlb_vpn), .tlb_ppn(tlb_ppn),
        .tlb_hit(tlb_hit), .tlb_fault(tlb_fault),
        .fill_valid(fill_valid), .fill_line_addr(fill_line_addr),
        .fill_data(fill_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_data(rsp_data),
        .miss_line_addr(miss_line_addr)
    );

    // TLB stub model, shared by the stub and the expectations.
    function automatic logic [PPN_W-1:0] map_ppn(input logic [VPN_W-1:0] v);
        if (v == 20'h00100 || v == 20'h00200) return 16'h0777;
        return v[15:0] ^ 16'h0A00;
    endfunction

    always_comb begin
        tlb_ppn   = map_ppn(tlb_vpn);
        tlb_hit   = (tlb_vpn[19:16] != 4'hF);
        tlb_fault = (tlb_vpn[19:16] == 4'hE);
    end

    function automatic logic [LA_W-1:0] line_of(input logic [VA_W-1:0] va);
        return {map_ppn(va[VA_W-1:PAGE_BITS]), va[PAGE_BITS-1:OFF_BITS]};
    endfunction

    task automatic check(input bit ok, input string what, input string got, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", what, got, exp);
        end
    endtask

    // Queue the expected outcome and drive one request cycle.
    task automatic lookup(input logic [VA_W-1:0] va, input int kind,
                          input logic [LINE_W-1:0] d, input string tag);
        exp_t e;
        e.kind = kind; e.data = (kind == 0) ? d : '0;
        e.line = (kind == 1) ? line_of(va) : '0; e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [VA_W-1:0] va, input logic [LINE_W-1:0] d);
        fill_valid = 1'b1; fill_line_addr = line_of(va); fill_data = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Monitor: compare each response with the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected response", "rsp_valid=1", "idle");
                end else begin
                    exp_t e;
                    logic [2:0] expf;
                    e = sb.pop_front();
                    expf = (e.kind == 0) ? 3'b100 : (e.kind == 1) ? 3'b010 : 3'b001;
                    check({rsp_hit, rsp_miss, rsp_fault} == expf &&
                          rsp_data == e.data && miss_line_addr == e.line, e.tag,
                          $sformatf("hmf=%b data=%h line=%h", {rsp_hit, rsp_miss, rsp_fault}, rsp_data, miss_line_addr),
                          $sformatf("hmf=%b data=%h line=%h", expf, e.data, e.line));
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            check(1'b0, "watchdog", "running", "finished");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [LINE_W-1:0] DA = {4{32'hA5A5_0001}};
    localparam logic [LINE_W-1:0] DX = {4{32'h5A5A_0002}};
    localparam logic [LINE_W-1:0] DF = {4{32'hDEAD_0003}};
    localparam logic [LINE_W-1:0] D1 = {4{32'h1111_0011}};
    localparam logic [LINE_W-1:0] D2 = {4{32'h2222_0012}};
    localparam logic [LINE_W-1:0] D3 = {4{32'h3333_0013}};
    localparam logic [LINE_W-1:0] D7 = {4{32'h7777_0017}};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault, "R1 reset outputs",
              $sformatf("%b", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}), "0000");

        // R2: TLB port follows the request in its own cycle
        req_valid = 1'b1; req_vaddr = 32'h0000_1230;
        #1;
        check(tlb_req && tlb_vpn == 20'h00001, "R2 tlb port",
              $sformatf("%b %h", tlb_req, tlb_vpn), "1 00001");
        req_valid = 1'b0;
        #1;
        check(!tlb_req, "R2 tlb_req idle", $sformatf("%b", tlb_req), "0");
        @(negedge clk);

        // R1 R7: cold miss reports the physical line
        lookup(32'h0000_1230, 1, '0, "R1 R7 cold miss");
        fill(32'h0000_1230, DA);
        // R4: hit returns the line
        lookup(32'h0000_1230, 0, DA, "R4 hit after fill");
        lookup(32'h0000_123C, 0, DA, "R4 hit other byte");

        // R5: physical tags, aliases share one line
        lookup(32'h0010_0450, 1, '0, "R5 alias first miss");
        fill(32'h0010_0450, DX);
        lookup(32'h0020_0458, 0, DX, "R5 alias hit");
        lookup(32'h0000_3450, 1, '0, "R5 other page same index");

        // R6: fault overrides a matching tag, TLB miss also faults
        fill(32'h0000_5670, DF);
        lookup(32'h0000_5670, 0, DF, "R6 baseline hit");
        lookup(32'hE000_5670, 2, '0, "R6 fault over match");
        lookup(32'hF000_5670, 2, '0, "R6 tlb miss");

        // R8: round-robin within set 9
        fill(32'h0001_1090, D1);
        fill(32'h0001_2090, D2);
        lookup(32'h0001_1090, 0, D1, "R8 way0 line");
        lookup(32'h0001_2090, 0, D2, "R8 way1 line");
        fill(32'h0001_3090, D3);
        lookup(32'h0001_1090, 1, '0, "R8 oldest evicted");
        lookup(32'h0001_2090, 0, D2, "R8 second kept");
        lookup(32'h0001_3090, 0, D3, "R8 third present");

        // R9: fill and lookup of the same line in one cycle
        begin
            exp_t e;
            e.kind = 1; e.data = '0; e.line = line_of(32'h0001_70B0);
            e.tag = "R9 same-cycle fill sees old";
            sb.push_back(e);
            req_valid = 1'b1; req_vaddr = 32'h0001_70B0;
            fill_valid = 1'b1; fill_line_addr = line_of(32'h0001_70B0); fill_data = D7;
            @(negedge clk);
            req_valid = 1'b0; fill_valid = 1'b0;
        end
        lookup(32'h0001_70B0, 0, D7, "R9 next lookup sees fill");

        // R3: idle gap gives no response
        @(negedge clk);
        @(negedge clk);
        check(!rsp_valid, "R3 idle no response", $sformatf("%b", rsp_valid), "0");
        check(sb.size() == 0, "R3 all responses seen", $sformatf("%0d", sb.size()), "0");

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule